// File: doc/BRIEF.md
# Trigger Capture and Gating Unit

This unit takes a bundle of raw trigger lines and does two things with them. First, a capture register takes a snapshot of every line when a strobe arrives. It keeps that snapshot until a clear is applied, so the pattern that caused an event can be read back later through the register port. Second, each line has a per-source enable bit and a programmable 1-in-n down-scaler. Only enabled sources produce output pulses, and they do so on every n-th rising edge.

The enable mask is presented as static levels on its own output bus, so downstream logic can use it directly. All settings are written and read through a simple single-cycle port. Address 0 holds the enable mask. Address 1 holds the captured pattern, which is read-only. Addresses 2 to 2+NSRC-1 hold the scale factor of each source, in source order. The read data is combinational from the address. The trigger lines are assumed to be synchronous to the clock.

Top module: `trig_capture_gate`

## Requirements
- R1: After reset the enable mask is 0, the captured pattern is 0, every gated output is 0, and every scale factor reads back as 1.
- R2: A strobe while the capture register is empty copies trig_in into the captured pattern at the next clock edge. The pattern is visible on latched_out and at read address 1.
- R3: Once a pattern has been captured, further strobes leave it unchanged until a clear is applied.
- R4: A clear zeroes the captured pattern at the next edge and re-arms capture. A clear wins over a strobe in the same cycle.
- R5: Writing address 0 sets the enable mask. The mask appears as steady levels on enable_out and reads back at address 0.
- R6: A source whose enable bit is 0 never raises its gated output.
- R7: With a scale factor of 1, every rising edge of an enabled source gives a one-cycle pulse on its gated output, in the cycle after the edge is sampled.
- R8: With a scale factor n greater than 1, an enabled source pulses on its n-th, 2n-th, and later rising edges. A factor of 0 behaves as 1.
- R9: A trigger line held high for several cycles counts as one edge only.
- R10: A write to address 0 or to any scale-factor address restarts every source's edge count from zero. A write to address 1 has no effect.
- R11: The scale factor of source i is written at, and reads back from, address 2+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NSRC | Raw trigger lines |
| latch_strobe | input | 1 | Capture request for the trigger pattern |
| latch_clear | input | 1 | Clears the captured pattern and re-arms capture |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| latched_out | output | NSRC | Captured trigger pattern |
| enable_out | output | NSRC | Enable mask as levels |
| trig_out | output | NSRC | Gated, down-scaled trigger pulses |

## Verification
The gating path is driven with a mixed pattern that pulses sources with factors 1, 3 and 0 together with a disabled source. This separates per-source counting from shared counting and confirms that the mask blocks output. A line held high over several cycles distinguishes edge counting from level counting. A partial count followed by a configuration write, and by a write to the read-only address, distinguishes a proper restart from a spurious one. The capture path is tried with a first strobe, a second strobe carrying a different pattern, and a clear coinciding with a strobe. These show whether the hold and the clear priority are correct.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    localparam int unsigned ADDR_ENABLE     = 0;
    localparam int unsigned ADDR_LATCH      = 1;
    localparam int unsigned ADDR_PRESC_BASE = 2;

    typedef enum logic [1:0] {
        REG_ENABLE,
        REG_LATCH,
        REG_PRESC,
        REG_NONE
    } reg_kind_e;

    function automatic reg_kind_e decode_addr(input int unsigned a, input int unsigned nsrc);
        if (a == ADDR_ENABLE)
            return REG_ENABLE;
        if (a == ADDR_LATCH)
            return REG_LATCH;
        if (a >= ADDR_PRESC_BASE && a < ADDR_PRESC_BASE + nsrc)
            return REG_PRESC;
        return REG_NONE;
    endfunction

endpackage

// File: rtl/tlu_latch.sv
module tlu_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         clear,
    input  logic [W-1:0] trig,
    output logic [W-1:0] pattern
);

    typedef struct packed {
        logic [W-1:0] pat;
        logic         held;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clear) begin
            lat_d.pat  = '0;
            lat_d.held = 1'b0;
        end else if (strobe && !lat_q.held) begin
            lat_d.pat  = trig;
            lat_d.held = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else
            lat_q <= lat_d;
    end

    assign pattern = lat_q.pat;

endmodule

// File: rtl/tlu_prescaler.sv
module tlu_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          enable,
    input  logic [PW-1:0] limit,
    input  logic          restart,
    output logic          fire
);

    typedef struct packed {
        logic          prev;
        logic [PW-1:0] cnt;
        logic          fire;
    } ps_t;

    ps_t ps_d, ps_q;

    logic          rise;
    logic [PW:0]   eff_limit;
    logic [PW:0]   next_cnt;

    always_comb begin
        ps_d      = ps_q;
        ps_d.prev = trig;
        ps_d.fire = 1'b0;
        rise      = trig & ~ps_q.prev;
        eff_limit = (limit == '0) ? (PW+1)'(1) : {1'b0, limit};
        next_cnt  = {1'b0, ps_q.cnt} + (PW+1)'(1);
        if (restart) begin
            ps_d.cnt = '0;
        end else if (enable && rise) begin
            if (next_cnt >= eff_limit) begin
                ps_d.cnt  = '0;
                ps_d.fire = 1'b1;
            end else begin
                ps_d.cnt = next_cnt[PW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_q <= '0;
        else
            ps_q <= ps_d;
    end

    assign fire = ps_q.fire;

endmodule

// File: rtl/tlu_regs.sv
module tlu_regs
    import tlu_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int PW   = 8,
    parameter int DW   = 16,
    parameter int AW   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic [NSRC-1:0]          latched,
    output logic [DW-1:0]            rdata,
    output logic [NSRC-1:0]          enable,
    output logic [NSRC-1:0][PW-1:0]  limits,
    output logic                     restart
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0]         en;
        logic [NSRC-1:0][PW-1:0] lim;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    reg_kind_e kind;
    logic [IW-1:0] sel;

    always_comb begin
        kind  = decode_addr(32'(addr), NSRC);
        sel   = IW'(addr - AW'(ADDR_PRESC_BASE));
        cfg_d = cfg_q;
        if (wr) begin
            case (kind)
                REG_ENABLE: cfg_d.en       = wdata[NSRC-1:0];
                REG_PRESC:  cfg_d.lim[sel] = wdata[PW-1:0];
                default: ;
            endcase
        end
        rdata = '0;
        case (kind)
            REG_ENABLE: rdata[NSRC-1:0] = cfg_q.en;
            REG_LATCH:  rdata[NSRC-1:0] = latched;
            REG_PRESC:  rdata[PW-1:0]   = cfg_q.lim[sel];
            default: ;
        endcase
        restart = wr && (kind == REG_ENABLE || kind == REG_PRESC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.en <= '0;
            for (int i = 0; i < NSRC; i++)
                cfg_q.lim[i] <= PW'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable = cfg_q.en;
    assign limits = cfg_q.lim;

endmodule

// File: rtl/trig_capture_gate.sv
module trig_capture_gate #(
    parameter int NSRC = 16,
    parameter int PW   = 8,
    parameter int DW   = 16,
    parameter int AW   = $clog2(NSRC + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] trig_in,
    input  logic            latch_strobe,
    input  logic            latch_clear,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NSRC-1:0] latched_out,
    output logic [NSRC-1:0] enable_out,
    output logic [NSRC-1:0] trig_out
);

    logic [NSRC-1:0][PW-1:0] limits;
    logic                    restart;

    tlu_latch #(.W(NSRC)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (latch_strobe),
        .clear   (latch_clear),
        .trig    (trig_in),
        .pattern (latched_out)
    );

    tlu_regs #(.NSRC(NSRC), .PW(PW), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .latched (latched_out),
        .rdata   (reg_rdata),
        .enable  (enable_out),
        .limits  (limits),
        .restart (restart)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        tlu_prescaler #(.PW(PW)) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (trig_in[g]),
            .enable  (enable_out[g]),
            .limit   (limits[g]),
            .restart (restart),
            .fire    (trig_out[g])
        );
    end

endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
    parameter int NSRC = 16,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] trig_in,
    input logic            latch_clear,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [NSRC-1:0] latched_out,
    input logic [NSRC-1:0] enable_out,
    input logic [NSRC-1:0] trig_out
);

    logic cfg_write;
    assign cfg_write = reg_wr &&
                       (reg_addr == AW'(0) ||
                        (32'(reg_addr) >= 2 && 32'(reg_addr) < NSRC + 2));

    p_hold_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_out != '0 && !latch_clear) |=> $stable(latched_out));

    p_clear_zeroes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clear |=> (latched_out == '0));

    p_enable_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == AW'(0)) |=> $stable(enable_out));

    p_gated_by_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out & ~enable_out) == '0);

    p_from_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out & ~$past(trig_in)) == '0);

    p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out & $past(trig_out)) == '0);

    p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write |=> (trig_out == '0));

endmodule

bind trig_capture_gate tlu_checker #(.NSRC(NSRC), .AW(AW)) u_chk (.*);

// File: tb/trig_capture_gate_test.sv
`timescale 1ns/1ps
module trig_capture_gate_test;

    localparam int NSRC = 16;
    localparam int PW   = 8;
    localparam int DW   = 16;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] trig_in = '0;
    logic            latch_strobe = 1'b0;
    logic            latch_clear = 1'b0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic [NSRC-1:0] latched_out;
    logic [NSRC-1:0] enable_out;
    logic [NSRC-1:0] trig_out;

    trig_capture_gate #(.NSRC(NSRC), .PW(PW), .DW(DW), .AW(AW)) uut (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic [NSRC-1:0] v;
        string           tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    logic [NSRC-1:0] m_en   = '0;
    logic [NSRC-1:0] m_prev = '0;
    int              m_cnt[NSRC];
    int              m_lim[NSRC];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (a == 0) m_en = d[NSRC-1:0];
        if (a >= 2 && a < NSRC + 2) m_lim[a-2] = int'(d[PW-1:0]);
        if (a == 0 || (a >= 2 && a < NSRC + 2))
            for (int i = 0; i < NSRC; i++) m_cnt[i] = 0;
    endtask

    task automatic rd(int a, logic [DW-1:0] exp, string tag);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    // driver: one cycle of trigger input, expected output queued for the monitor
    task automatic drive(logic [NSRC-1:0] v, string tag);
        logic [NSRC-1:0] e;
        int eff;
        @(negedge clk);
        trig_in = v;
        e = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (m_en[i] && v[i] && !m_prev[i]) begin
                eff = (m_lim[i] == 0) ? 1 : m_lim[i];
                if (m_cnt[i] + 1 >= eff) begin
                    e[i] = 1'b1;
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i]++;
                end
            end
        end
        m_prev = v;
        @(posedge clk);
        #1;
        sbq.push_back('{v: e, tag: tag});
    endtask

    task automatic strobe_cycle(logic [NSRC-1:0] v, logic clr);
        @(negedge clk);
        trig_in      = v;
        latch_strobe = 1'b1;
        latch_clear  = clr;
        @(negedge clk);
        latch_strobe = 1'b0;
        latch_clear  = 1'b0;
        #1;
    endtask

    task automatic clear_cycle();
        @(negedge clk);
        latch_clear = 1'b1;
        @(negedge clk);
        latch_clear = 1'b0;
        #1;
    endtask

    // monitor: compares gated outputs against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (sbq.size() > 0) begin
                mon_e = sbq.pop_front();
                chk(mon_e.tag, 32'(trig_out), 32'(mon_e.v));
            end else if (trig_out != '0) begin
                chk("R6 unexpected trig_out", 32'(trig_out), 32'(0));
            end
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) begin
            m_cnt[i] = 0;
            m_lim[i] = 1;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 enable_out", 32'(enable_out), 32'(0));
        chk("R1 latched_out", 32'(latched_out), 32'(0));
        chk("R1 trig_out", 32'(trig_out), 32'(0));
        rd(0, 16'h0000, "R1 enable readback");
        rd(2, 16'h0001, "R1 scale src0");
        rd(17, 16'h0001, "R1 scale src15");

        // R2 capture
        strobe_cycle(16'hA5C3, 1'b0);
        chk("R2 latched_out", 32'(latched_out), 32'hA5C3);
        rd(1, 16'hA5C3, "R2 readback");

        // R3 hold
        strobe_cycle(16'h0F0F, 1'b0);
        chk("R3 hold after strobe", 32'(latched_out), 32'hA5C3);

        // R4 clear and priority
        clear_cycle();
        chk("R4 cleared", 32'(latched_out), 32'h0);
        strobe_cycle(16'h1234, 1'b1);
        chk("R4 clear beats strobe", 32'(latched_out), 32'h0);
        strobe_cycle(16'h1234, 1'b0);
        chk("R4 re-armed capture", 32'(latched_out), 32'h1234);

        // R10 write to address 1 ignored
        wr(1, 16'hFFFF);
        chk("R10 addr1 write latched", 32'(latched_out), 32'h1234);
        chk("R10 addr1 write enable", 32'(enable_out), 32'h0);
        clear_cycle();
        @(negedge clk);
        trig_in = '0;
        m_prev  = '0;
        @(negedge clk);

        // R5 enable mask
        wr(0, 16'h00FF);
        @(negedge clk);
        chk("R5 enable_out", 32'(enable_out), 32'h00FF);
        rd(0, 16'h00FF, "R5 readback");

        // R11 scale factors
        wr(3, 16'h0003);
        wr(4, 16'h0000);
        rd(3, 16'h0003, "R11 scale src1");
        rd(4, 16'h0000, "R11 scale src2");

        // R6 R7 R8 mixed pulses
        for (int k = 0; k < 6; k++) begin
            drive(16'h0107, "R7 R8 R6 mixed pulse");
            drive(16'h0000, "R7 R8 gap");
        end

        // R9 held level counts once
        drive(16'h0001, "R9 first high");
        drive(16'h0001, "R9 still high");
        drive(16'h0001, "R9 still high");
        drive(16'h0000, "R9 release");

        // R10 restart on configuration write
        drive(16'h0002, "R10 partial count");
        drive(16'h0000, "R10 gap");
        wr(3, 16'h0003);
        for (int k = 0; k < 3; k++) begin
            drive(16'h0002, "R10 after restart");
            drive(16'h0000, "R10 gap");
        end

        // R10 write to address 1 keeps counts
        drive(16'h0002, "R10 count one");
        drive(16'h0000, "R10 gap");
        wr(1, 16'h0000);
        drive(16'h0002, "R10 count two");
        drive(16'h0000, "R10 gap");
        drive(16'h0002, "R10 count three fires");
        drive(16'h0000, "R10 gap");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule